// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block is the host side of a three-wire write link to a low-power voltage-output DAC. It accepts one request at a time through a valid/ready handshake. Each request carries a 2-bit operating-mode field and a 14-bit output code. The block turns the request into a 16-bit serial frame on a frame-select line, a serial clock and a data line. The serial clock comes from the system clock through a half-period counter. The time from frame-select low to the first clock fall, and the minimum frame-select high time between frames, are also counted in system-clock cycles. All three counts are parameters.

The receiving DAC samples data on falling clock edges and acts on the word at its 16th falling edge. An optional low-power idle policy, selected by an input, parks frame-select low between writes and raises it for the minimum high time just before the next frame. For testing, an abort input ends a frame early by raising frame-select before the 16th falling edge, so that the receiver discards the write. A completed frame is reported by a one-cycle done pulse.

Top module: `dacw_seq`

## Requirements
- R1: A frame carries 16 bits, most significant first. Bits [15:14] are the mode field `req_mode_i` and bits [13:0] are `req_code_i`. The receiver takes one bit at each falling edge of `dac_sclk_o` while `dac_sync_o` is low.
- R2: While `dac_sync_o` stays low, `dac_din_o` changes only in the cycle where `dac_sclk_o` rises. It is therefore stable across every falling edge.
- R3: Inside a frame every low and high phase of `dac_sclk_o` lasts exactly HALF_CYC system cycles. Each phase must be at least 13 ns and the full period at least 1/30 MHz for the configured clock period.
- R4: `dac_sclk_o` is high whenever `dac_sync_o` changes level. The first falling edge of `dac_sclk_o` comes exactly SETUP_CYC cycles after `dac_sync_o` falls, which must be at least 13 ns.
- R5: Before every falling edge, `dac_sync_o` has been high for at least HIGH_CYC cycles, which must be at least 33 ns.
- R6: A request is taken in a cycle where `req_valid_i` and `req_ready_o` are both high. From then on `req_ready_o` is low for SETUP_CYC + 31*HALF_CYC + HIGH_CYC cycles. It is low for HIGH_CYC more cycles when `dac_sync_o` was parked low at acceptance.
- R7: `done_o` pulses for one cycle, in the same cycle where `dac_sync_o` rises, HALF_CYC cycles after the 16th falling edge. It pulses only for frames that were not aborted.
- R8: With `idle_low_i` high, `dac_sync_o` drops low when the post-frame high interval ends and stays low while idle. The next frame starts with a high pulse of exactly HIGH_CYC cycles.
- R9: If `abort_i` is high during a frame before the 16th falling edge, `dac_sync_o` goes high at the next clock with fewer than 16 falling edges sent. No done pulse is given, and the post-frame high interval follows.
- R10: `abort_i` has no effect while the block is idle or after the 16th falling edge. The outputs stay as they were, and a frame in its last phase completes with done.
- R11: During reset `dac_sync_o` and `dac_sclk_o` are high and `dac_din_o`, `done_o` and `req_ready_o` are low. After reset is released, `req_ready_o` stays low for HIGH_CYC cycles.
- R12: If `idle_low_i` is cleared while `dac_sync_o` is parked low, `dac_sync_o` rises and `req_ready_o` is low for HIGH_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer can take a request |
| req_mode_i | input | MODE_W (2) | Operating-mode field, sent first |
| req_code_i | input | CODE_W (14) | Output code |
| idle_low_i | input | 1 | Park frame-select low between frames |
| abort_i | input | 1 | Cancel the frame in progress |
| dac_sync_o | output | 1 | Frame select, active low |
| dac_sclk_o | output | 1 | Serial clock, idles high |
| dac_din_o | output | 1 | Serial data |
| done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
The bench models the receiver. It shifts in the data line at every falling clock edge and times every level of frame-select and of the serial clock. Because of this, a word sent in the wrong bit order shows up as a mismatch, and so does a data change on a falling edge or a phase that is one cycle short. The abort tests stop a frame after 0, 1, 8 and 15 falling edges, and also after the 16th. A design that let the 16th edge through before raising frame-select, or that honoured a late abort, would show the wrong edge count or the wrong number of done pulses. In parked-idle mode the bench measures the pre-frame high pulse and the longer busy window. A design that skipped the pulse would start a frame with no valid frame-select edge, and the bench would report that.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RAISE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_GAP
   } seq_state_t;

endpackage

// File: rtl/dacw_timer.sv
module dacw_timer #(
   parameter int W       = 4,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= W'(RST_VAL);
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dacw_shreg.sv
module dacw_shreg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_word_i,
   input  logic         shift_i,
   output logic         msb_o
);

   logic [W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (load_i)
         word_q <= load_word_i;
      else if (shift_i)
         word_q <= {word_q[W-2:0], 1'b0};
   end

   assign msb_o = word_q[W-1];

endmodule

// File: rtl/dacw_seq.sv
module dacw_seq
   import dacw_pkg::*;
#(
   parameter int MODE_W        = 2,
   parameter int CODE_W        = 14,
   parameter int HALF_CYC      = 3,
   parameter int SETUP_CYC     = 2,
   parameter int HIGH_CYC      = 5,
   parameter int CLK_PS        = 8000,
   parameter bit TIMING_CHECKS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [MODE_W-1:0] req_mode_i,
   input  logic [CODE_W-1:0] req_code_i,
   input  logic              idle_low_i,
   input  logic              abort_i,
   output logic              dac_sync_o,
   output logic              dac_sclk_o,
   output logic              dac_din_o,
   output logic              done_o
);

   localparam int FRAME_BITS = MODE_W + CODE_W;
   localparam int FALL_W     = $clog2(FRAME_BITS + 1);
   localparam int MAX_A      = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
   localparam int TMAX       = (MAX_A > HIGH_CYC) ? MAX_A : HIGH_CYC;
   localparam int TMR_W      = $clog2(TMAX + 1);
   localparam logic [TMR_W-1:0]  LD_HALF  = TMR_W'(HALF_CYC - 1);
   localparam logic [TMR_W-1:0]  LD_SETUP = TMR_W'(SETUP_CYC - 1);
   localparam logic [TMR_W-1:0]  LD_HIGH  = TMR_W'(HIGH_CYC - 1);
   localparam logic [FALL_W-1:0] LAST_FALL = FALL_W'(FRAME_BITS);

   seq_state_t        st_q, st_d;
   logic              sync_q, sync_d, sclk_q, sclk_d, done_q, done_d;
   logic [FALL_W-1:0] falls_q, falls_d;
   logic              tmr_ld, tmr_zero;
   logic [TMR_W-1:0]  tmr_val;
   logic              sh_load, sh_shift, accept, late_abort;

   dacw_timer #(.W(TMR_W), .RST_VAL(HIGH_CYC - 1)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_ld), .load_val_i(tmr_val), .zero_o(tmr_zero)
   );

   dacw_shreg #(.W(FRAME_BITS)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load_i(sh_load), .load_word_i({req_mode_i, req_code_i}),
      .shift_i(sh_shift), .msb_o(dac_din_o)
   );

   assign req_ready_o = (st_q == ST_IDLE);
   assign accept      = req_valid_i && req_ready_o;
   // an abort is honoured only while the 16th falling edge is still ahead
   assign late_abort  = abort_i && ((st_q == ST_SETUP) || (st_q == ST_HIGH) ||
                                    ((st_q == ST_LOW) && (falls_q != LAST_FALL)));

   always_comb begin
      st_d     = st_q;
      sync_d   = sync_q;
      sclk_d   = sclk_q;
      done_d   = 1'b0;
      falls_d  = falls_q;
      tmr_ld   = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      if (late_abort) begin
         st_d    = ST_GAP;
         sync_d  = 1'b1;
         sclk_d  = 1'b1;
         tmr_ld  = 1'b1;
         tmr_val = LD_HIGH;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  sh_load = 1'b1;
                  tmr_ld  = 1'b1;
                  sync_d  = 1'b1;
                  if (!sync_q) begin
                     st_d    = ST_RAISE;
                     tmr_val = LD_HIGH;
                  end else begin
                     st_d    = ST_SETUP;
                     sync_d  = 1'b0;
                     falls_d = '0;
                     tmr_val = LD_SETUP;
                  end
               end else if (idle_low_i && sync_q) begin
                  sync_d = 1'b0;
               end else if (!idle_low_i && !sync_q) begin
                  st_d    = ST_GAP;
                  sync_d  = 1'b1;
                  tmr_ld  = 1'b1;
                  tmr_val = LD_HIGH;
               end
            end
            ST_RAISE: if (tmr_zero) begin
               st_d    = ST_SETUP;
               sync_d  = 1'b0;
               falls_d = '0;
               tmr_ld  = 1'b1;
               tmr_val = LD_SETUP;
            end
            ST_SETUP, ST_HIGH: if (tmr_zero) begin
               st_d    = ST_LOW;
               sclk_d  = 1'b0;
               falls_d = falls_q + 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = LD_HALF;
            end
            ST_LOW: if (tmr_zero) begin
               sclk_d = 1'b1;
               tmr_ld = 1'b1;
               if (falls_q == LAST_FALL) begin
                  st_d    = ST_GAP;
                  sync_d  = 1'b1;
                  done_d  = 1'b1;
                  tmr_val = LD_HIGH;
               end else begin
                  st_d     = ST_HIGH;
                  sh_shift = 1'b1;
                  tmr_val  = LD_HALF;
               end
            end
            ST_GAP: if (tmr_zero) begin
               st_d   = ST_IDLE;
               sync_d = !idle_low_i;
            end
            default: st_d = ST_GAP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_GAP;
         sync_q  <= 1'b1;
         sclk_q  <= 1'b1;
         done_q  <= 1'b0;
         falls_q <= '0;
      end else begin
         st_q    <= st_d;
         sync_q  <= sync_d;
         sclk_q  <= sclk_d;
         done_q  <= done_d;
         falls_q <= falls_d;
      end
   end

   assign dac_sync_o = sync_q;
   assign dac_sclk_o = sclk_q;
   assign done_o     = done_q;

   AST_DIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (!dac_sync_o && $past(!dac_sync_o) && (dac_din_o != $past(dac_din_o))) |-> $rose(dac_sclk_o)); // R2
   AST_SCLK_AT_SYNC_EDGE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(dac_sync_o) || $fell(dac_sync_o)) |-> dac_sclk_o); // R4
   AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid_i && req_ready_o) |=> !req_ready_o); // R6
   AST_DONE_WITH_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $rose(dac_sync_o)); // R7
   AST_ABORT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n) late_abort |=> (dac_sync_o && !done_o)); // R9

   generate
      if (TIMING_CHECKS) begin : g_timing_chk
         localparam int RUN_W = $clog2(4 * TMAX + 2);
         logic             sync_seen_q, sclk_seen_q;
         logic [RUN_W-1:0] sync_run_q, sclk_run_q, sclk_prev_run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_seen_q     <= 1'b1;
               sclk_seen_q     <= 1'b1;
               sync_run_q      <= '0;
               sclk_run_q      <= '0;
               sclk_prev_run_q <= '0;
            end else begin
               sync_seen_q <= dac_sync_o;
               sclk_seen_q <= dac_sclk_o;
               if (dac_sync_o != sync_seen_q)
                  sync_run_q <= RUN_W'(1);
               else if (sync_run_q != '1)
                  sync_run_q <= sync_run_q + 1'b1;
               if (dac_sclk_o != sclk_seen_q) begin
                  sclk_run_q      <= RUN_W'(1);
                  sclk_prev_run_q <= sclk_run_q;
               end else if (sclk_run_q != '1) begin
                  sclk_run_q <= sclk_run_q + 1'b1;
               end
            end
         end

         AST_SCLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(dac_sclk_o) |-> (int'(sclk_run_q) * CLK_PS >= 13000)); // R3
         AST_SCLK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n) ($rose(dac_sclk_o) && !dac_sync_o) |-> (int'(sclk_run_q) * CLK_PS >= 13000)); // R3
         AST_SCLK_RATE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(dac_sclk_o) && $past(!dac_sync_o) && !$fell(dac_sync_o)) |-> ((int'(sclk_run_q) + int'(sclk_prev_run_q)) * CLK_PS >= 33334 || sclk_prev_run_q == '0)); // R3
         AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(dac_sclk_o) |-> (!dac_sync_o && int'(sync_run_q) * CLK_PS >= 13000)); // R4
         AST_SYNC_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(dac_sync_o) |-> (int'(sync_run_q) >= HIGH_CYC && HIGH_CYC * CLK_PS >= 33000)); // R5
      end
   endgenerate

endmodule

// File: tb/test_dacw_seq.sv
module test_dacw_seq;

   localparam int HALF  = 3;
   localparam int SETUP = 2;
   localparam int HIGH  = 5;
   localparam int FB    = 16;
   localparam int BUSY  = SETUP + (2 * FB - 1) * HALF + HIGH;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_mode = '0;
   logic [13:0] req_code = '0;
   logic        idle_low = 1'b0;
   logic        abort = 1'b0;
   logic        ready, sync, sclk, din, done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   dacw_seq #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .HIGH_CYC(HIGH), .CLK_PS(8000)) i_dacw_seq (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
      .req_mode_i(req_mode), .req_code_i(req_code), .idle_low_i(idle_low), .abort_i(abort),
      .dac_sync_o(sync), .dac_sclk_o(sclk), .dac_din_o(din), .done_o(done)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // receiver model, evaluated on falling system-clock edges
   logic        p_sync = 1'b1, p_sclk = 1'b1, p_din = 1'b0;
   int          sync_run = 0, sclk_run = 0, since_sf = 0, falls = 0;
   logic [15:0] word = '0, last_word = '0;
   int          last_falls = 0, done_cnt = 0, last_hi = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_sync && !sync) begin
            chk(sync_run >= HIGH, "R5", "sync high run before fall", sync_run, HIGH);
            chk(sclk, "R4", "sclk at sync fall", sclk, 1);
            last_hi = sync_run; since_sf = 0; falls = 0; word = '0;
         end
         if (p_sclk && !sclk) begin
            chk(!sync, "R4", "sclk fall with sync high", sync, 0);
            chk(din == p_din, "R2", "din moved at falling edge", din, p_din);
            if (falls == 0) chk(since_sf == SETUP, "R4", "sync-to-first-fall cycles", since_sf, SETUP);
            else chk(sclk_run == HALF, "R3", "sclk high phase", sclk_run, HALF);
            word = {word[14:0], din};
            falls++;
         end
         if (!p_sclk && sclk && (!sync || falls == FB))
            chk(sclk_run == HALF, "R3", "sclk low phase", sclk_run, HALF);
         if (!p_sync && sync) begin
            chk(sclk, "R4", "sclk at sync rise", sclk, 1);
            chk(done == (falls == FB), "R7", "done at sync rise", done, falls == FB);
            last_falls = falls; last_word = word;
         end else if (done) begin
            chk(1'b0, "R7", "done without sync rise", done, 0);
         end
         if (done) done_cnt++;
      end
      sync_run = (sync == p_sync) ? sync_run + 1 : 1;
      sclk_run = (sclk == p_sclk) ? sclk_run + 1 : 1;
      since_sf++;
      p_sync = sync; p_sclk = sclk; p_din = din;
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // abort_at: -1 none, 0..15 abort after that many falls, 16 abort after the last fall
   task automatic send(input logic [1:0] m, input logic [13:0] c, input int abort_at, input int exp_busy, input string req);
      int  busy;
      int  d0;
      bit  fired;
      req_mode = m; req_code = c; req_valid = 1'b1;
      while (!ready) tick();
      tick();
      req_valid = 1'b0;
      d0 = done_cnt; busy = 0; fired = 1'b0;
      while (!ready) begin
         abort = 1'b0;
         if (abort_at >= 0 && !fired && !sync && falls == abort_at) begin
            abort = 1'b1; fired = 1'b1;
         end
         busy++;
         tick();
      end
      abort = 1'b0;
      if (exp_busy >= 0) chk(busy == exp_busy, "R6", {req, " busy window"}, busy, exp_busy);
      if (abort_at < 0 || abort_at == FB) begin
         chk(last_falls == FB, req, "falling edges in frame", last_falls, FB);
         chk(last_word == {m, c}, req, "received word", last_word, {m, c});
         chk(done_cnt == d0 + 1, "R7", "one done per frame", done_cnt - d0, 1);
      end else begin
         chk(last_falls == abort_at, "R9", "edges before abort", last_falls, abort_at);
         chk(done_cnt == d0, "R9", "no done on abort", done_cnt - d0, 0);
      end
   endtask

   initial begin
      int busy;
      int d0;
      repeat (3) tick();
      chk(sync == 1'b1, "R11", "sync in reset", sync, 1);
      chk(sclk == 1'b1, "R11", "sclk in reset", sclk, 1);
      chk(din == 1'b0, "R11", "din in reset", din, 0);
      chk(ready == 1'b0, "R11", "ready in reset", ready, 0);
      chk(done == 1'b0, "R11", "done in reset", done, 0);
      rst_n = 1'b1;
      busy = 0;
      while (!ready) begin busy++; tick(); end
      chk(busy == HIGH, "R11", "ready delay after reset", busy, HIGH);

      // R1 field order and bit order over a sweep of modes and codes
      for (int m = 0; m < 4; m++)
         for (int k = 0; k < 64; k++)
            send(2'(m), 14'((k * 257 + m * 4099) & 16'h3fff), -1, BUSY, "R1");
      for (int b = 0; b < 14; b++) send(2'(b & 3), 14'(1 << b), -1, BUSY, "R1");
      send(2'b00, 14'h0000, -1, BUSY, "R1");
      send(2'b11, 14'h3fff, -1, BUSY, "R1");

      // R10 abort while idle is ignored
      d0 = done_cnt;
      repeat (2) tick();
      abort = 1'b1;
      repeat (4) begin
         tick();
         chk(sync && sclk && ready, "R10", "idle outputs under abort", {sync, sclk, ready}, 3'b111);
      end
      abort = 1'b0;
      chk(done_cnt == d0, "R10", "no done from idle abort", done_cnt - d0, 0);

      // R9 aborts at several points, each followed by a clean frame
      send(2'b01, 14'h1234, 0, -1, "R9");
      send(2'b10, 14'h2aaa, -1, BUSY, "R9");
      send(2'b01, 14'h0f0f, 1, -1, "R9");
      send(2'b00, 14'h3c3c, 8, -1, "R9");
      send(2'b11, 14'h1555, 15, -1, "R9");
      send(2'b00, 14'h0001, -1, BUSY, "R9");
      // R10 abort after the last falling edge is ignored
      send(2'b10, 14'h2345, 16, BUSY, "R10");

      // R8 parked idle
      idle_low = 1'b1;
      repeat (3) tick();
      chk(sync == 1'b0, "R8", "sync parked low", sync, 0);
      for (int k = 0; k < 24; k++) begin
         send(2'(k & 3), 14'((k * 683) & 16'h3fff), -1, BUSY + HIGH, "R8");
         chk(last_hi == HIGH, "R8", "pre-frame high pulse", last_hi, HIGH);
         tick();
         chk(sync == 1'b0, "R8", "sync low after frame", sync, 0);
      end
      send(2'b01, 14'h2222, 5, -1, "R9");
      tick();
      chk(sync == 1'b0, "R8", "sync parked after aborted frame", sync, 0);

      // R12 leaving parked idle
      idle_low = 1'b0;
      tick();
      busy = 0;
      while (!ready) begin busy++; tick(); end
      chk(busy == HIGH, "R12", "ready low after unpark", busy, HIGH);
      chk(sync == 1'b1, "R12", "sync high after unpark", sync, 1);
      send(2'b10, 14'h0abc, -1, BUSY, "R12");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog all requirements actual=hung expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule